// File: doc/BRIEF.md
# Sideband Bus Host Register Front-End

This block is the memory-mapped register file of a host controller for a single-wire sideband bus. Software sets up control fields, a transfer header (target address, write length, read length) and up to 32 transmit bytes. It then sets the launch bit. The block passes the request to a separate bit-level engine through a start/done handshake. When the engine reports completion, the block stores the received bytes and the engine's cause flags. It raises one level-sensitive interrupt line.

The register bus is a plain 32-bit port: word address, write enable, write data, and combinational read data. The transmit and receive buffers each occupy two separate banks of four words. Bytes are packed little-endian inside each word. The engine and frame-check computation are outside this block.

Top module: `sbh_regs`

## Requirements
- R1: After reset, every register reads zero, `eng_start` is low and `irq` is low.
- R2: Control register at offset 0x00. Bit 0 is clock enable, bit 4 is controller enable, bit 5 is contention detect, bit 6 is input invert and bit 7 is output invert. Bits [19:16] are a sample point and bits [10:8] are a divider exponent. Other bits read zero. The fields are driven on `cfg_ctrl`.
- R3: Header register at offset 0x0C. Bits [7:0] are the target, bits [15:8] are the write length and bits [23:16] are the read length. A length field is written as min(value, 32). Bits [31:24] read zero.
- R4: Transmit bytes 0–15 sit in words 0x20–0x2C and bytes 16–31 in words 0x40–0x4C. Byte n of a word is bits [8n+7:8n]. The 32 bytes appear on `tx_data`, with byte k at bits [8k+7:8k].
- R5: Writing 1 to bit 0 of the command register (0x08) starts a transaction. The start is taken only if control bits 0 and 4 are both set and the block is idle. A taken start gives a one-cycle `eng_start` pulse one cycle after the write. Otherwise the write has no effect.
- R6: Command register bits [27:24] hold `eng_state` and bit 31 holds `eng_pin_busy`. Bit 0 reads 1 from an accepted start until `eng_done`. The block is idle when bits 31 and 27:24 are zero and no transaction is pending.
- R7: Writes to the header and transmit words are ignored while a transaction is pending.
- R8: The receive words (0x30–0x3C, 0x50–0x5C) load `rx_data` only in the cycle `eng_done` is high. They are read-only.
- R9: Interrupt status register at 0x1C. On `eng_done`, bit 0 (done) is set along with the `eng_err` flags: bit 1 checksum abort, bit 2 bad checksum, bit 3 contention, bit 4 timeout. Done is set even on errors. Writing 1 to a bit clears it and writing 0 leaves it unchanged.
- R10: Interrupt control register at 0x18. Bits [4:0] enable each cause and bits [31:30] are a negotiation select. `irq` = OR of (status & enable), and it follows a status change in the next cycle.
- R11: Writing 0 to the command register clears the launch bit and nothing else. The pending flag, the engine handshake and all other registers keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| bus_addr | input | 7 | byte address, word aligned |
| bus_we | input | 1 | write strobe |
| bus_wdata | input | 32 | write data |
| bus_rdata | output | 32 | read data (combinational) |
| cfg_ctrl | output | 32 | control register contents |
| cfg_nego_sel | output | 2 | negotiation select |
| hdr_target | output | 8 | target address |
| hdr_wr_len | output | 8 | write length |
| hdr_rd_len | output | 8 | read length |
| tx_data | output | 256 | transmit bytes |
| eng_start | output | 1 | start pulse to engine |
| eng_done | input | 1 | completion pulse from engine |
| eng_err | input | 4 | cause flags, valid with eng_done |
| eng_state | input | 4 | engine activity state |
| eng_pin_busy | input | 1 | pin monitor flag |
| rx_data | input | 256 | received bytes, valid with eng_done |
| irq | output | 1 | level interrupt |

## Verification
Register writes are visible on the read port one cycle after the write edge. A taken launch produces `eng_start` in the cycle after the write. Receive words and status bits change at the edge where `eng_done` is high. `irq` changes one cycle after the status change it reflects. Each task drives inputs on the falling edge and samples at the next falling edge after the register that produces the result. The engine stub waits a fixed few cycles after `eng_start` before it pulses done.

// File: rtl/sbh_regs.sv
module sbh_regs #(
  parameter int BUF_BYTES = 32,
  parameter int AW = 7
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [AW-1:0]          bus_addr,
  input  logic                   bus_we,
  input  logic [31:0]            bus_wdata,
  output logic [31:0]            bus_rdata,
  output logic [31:0]            cfg_ctrl,
  output logic [1:0]             cfg_nego_sel,
  output logic [7:0]             hdr_target,
  output logic [7:0]             hdr_wr_len,
  output logic [7:0]             hdr_rd_len,
  output logic [BUF_BYTES*8-1:0] tx_data,
  output logic                   eng_start,
  input  logic                   eng_done,
  input  logic [3:0]             eng_err,
  input  logic [3:0]             eng_state,
  input  logic                   eng_pin_busy,
  input  logic [BUF_BYTES*8-1:0] rx_data,
  output logic                   irq
);
  localparam int WORDS = BUF_BYTES / 4;
  localparam int HALF  = WORDS / 2;
  localparam logic [31:0] CTRL_MASK = 32'h000F_07F1;
  localparam logic [7:0]  LEN_MAX = 8'(BUF_BYTES);

  logic [31:0] ctrl_q;
  logic [23:0] hdr_q;
  logic        launch_q, pend_q, start_q;
  logic [4:0]  ien_q, ists_q;
  logic [1:0]  nego_q;
  logic [31:0] txw [WORDS];
  logic [31:0] rxw [WORDS];

  wire idle = !pend_q && eng_state == 4'd0 && !eng_pin_busy;
  wire wr_ctrl = bus_we && bus_addr == 7'h00;
  wire wr_cmd  = bus_we && bus_addr == 7'h08;
  wire wr_hdr  = bus_we && bus_addr == 7'h0C;
  wire wr_ien  = bus_we && bus_addr == 7'h18;
  wire wr_ists = bus_we && bus_addr == 7'h1C;
  wire go = wr_cmd && bus_wdata[0] && ctrl_q[0] && ctrl_q[4] && idle;

  function automatic logic [7:0] clip(input logic [7:0] v);
    return (v > LEN_MAX) ? LEN_MAX : v;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0; hdr_q <= '0; launch_q <= 1'b0; pend_q <= 1'b0;
      start_q <= 1'b0; ien_q <= '0; ists_q <= '0; nego_q <= '0;
    end else begin
      start_q <= go;
      if (wr_ctrl) ctrl_q <= bus_wdata & CTRL_MASK;
      if (wr_hdr && !pend_q)
        hdr_q <= {clip(bus_wdata[23:16]), clip(bus_wdata[15:8]), bus_wdata[7:0]};
      if (wr_ien) begin ien_q <= bus_wdata[4:0]; nego_q <= bus_wdata[31:30]; end
      if (go) begin launch_q <= 1'b1; pend_q <= 1'b1; end
      else if (wr_cmd && !bus_wdata[0]) launch_q <= 1'b0;
      if (eng_done && pend_q) begin launch_q <= 1'b0; pend_q <= 1'b0; end
      ists_q <= (ists_q & ~(wr_ists ? bus_wdata[4:0] : 5'd0))
              | (eng_done ? {eng_err, 1'b1} : 5'd0);
    end
  end

  for (genvar w = 0; w < WORDS; w++) begin : g_buf
    localparam logic [AW-1:0] TXA = AW'((w < HALF) ? 32'h20 + 4*w : 32'h40 + 4*(w-HALF));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        txw[w] <= '0; rxw[w] <= '0;
      end else begin
        if (bus_we && bus_addr == TXA && !pend_q) txw[w] <= bus_wdata;
        if (eng_done) rxw[w] <= rx_data[32*w +: 32];
      end
    end
    assign tx_data[32*w +: 32] = txw[w];
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      7'h00: bus_rdata = ctrl_q;
      7'h08: bus_rdata = {eng_pin_busy, 3'b0, eng_state, 23'b0, launch_q};
      7'h0C: bus_rdata = {8'h0, hdr_q};
      7'h18: bus_rdata = {nego_q, 25'b0, ien_q};
      7'h1C: bus_rdata = {27'b0, ists_q};
      default: begin
        for (int w = 0; w < WORDS; w++) begin
          if (bus_addr == AW'((w < HALF) ? 32'h20 + 4*w : 32'h40 + 4*(w-HALF)))
            bus_rdata = txw[w];
          if (bus_addr == AW'((w < HALF) ? 32'h30 + 4*w : 32'h50 + 4*(w-HALF)))
            bus_rdata = rxw[w];
        end
      end
    endcase
  end

  logic irq_q;
  always_ff @(posedge clk) irq_q <= rst_n && |(ists_q & ien_q);

  assign irq          = irq_q;
  assign eng_start    = start_q;
  assign cfg_ctrl     = ctrl_q;
  assign cfg_nego_sel = nego_q;
  assign hdr_target   = hdr_q[7:0];
  assign hdr_wr_len   = hdr_q[15:8];
  assign hdr_rd_len   = hdr_q[23:16];

  // R5
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start);
  // R3
  len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_wr_len <= LEN_MAX && hdr_rd_len <= LEN_MAX);
  // R9
  done_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done |=> ists_q[0]);
  // R7
  tx_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q && !eng_done |=> $stable(tx_data) && $stable(hdr_wr_len));
  // R5
  start_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> $past(ctrl_q[0] && ctrl_q[4]));
endmodule

// File: tb/sbh_regs_tb.sv
module sbh_regs_tb;
  localparam int CLK_PERIOD = 10;
  logic clk = 0, rst_n = 0;
  logic [6:0] bus_addr = '0;
  logic bus_we = 0;
  logic [31:0] bus_wdata = '0, bus_rdata, cfg_ctrl;
  logic [1:0] cfg_nego_sel;
  logic [7:0] hdr_target, hdr_wr_len, hdr_rd_len;
  logic [255:0] tx_data, rx_data = '0;
  logic eng_start, eng_done = 0, eng_pin_busy = 0, irq;
  logic [3:0] eng_err = '0, eng_state = '0;
  int n_chk = 0, n_bad = 0;
  int start_seen = 0;

  sbh_regs u_dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) if (eng_start) start_seen++;

  task automatic chk(string req, logic [255:0] act, logic [255:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [6:0] a, logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic rd(logic [6:0] a, output logic [31:0] d);
    bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic done_pulse(logic [3:0] err);
    @(negedge clk); eng_done = 1; eng_err = err;
    @(negedge clk); eng_done = 0; eng_err = 0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(7'h00, d); chk("R1 ctrl", d, 0);
    rd(7'h1C, d); chk("R1 ists", d, 0);
    rd(7'h40, d); chk("R1 tx", d, 0);
    chk("R1 irq", irq, 0);
    chk("R1 start", eng_start, 0);
  endtask

  task automatic t_ctrl;
    logic [31:0] d;
    wr(7'h00, 32'hFFFF_FFFF); rd(7'h00, d);
    chk("R2 mask", d, 32'h000F_07F1);
    chk("R2 port", cfg_ctrl, 32'h000F_07F1);
    wr(7'h18, 32'h8000_0015); rd(7'h18, d);
    chk("R10 ien read", d, 32'h8000_0015);
    chk("R10 nego", cfg_nego_sel, 2'b10);
  endtask

  task automatic t_hdr_tx;
    logic [31:0] d;
    wr(7'h0C, 32'hAB28_0530); rd(7'h0C, d);
    chk("R3 clip", d, 32'h0020_0530);
    chk("R3 ports", {hdr_rd_len, hdr_wr_len, hdr_target}, 24'h200530);
    wr(7'h0C, 32'h0004_1F30);
    chk("R3 len", hdr_wr_len, 8'h1F);
    for (int i = 0; i < 8; i++)
      wr(i < 4 ? 7'(32'h20 + 4*i) : 7'(32'h40 + 4*(i-4)), 32'h1000_0000 * i + 32'h0403_0201);
    chk("R4 byte0", tx_data[7:0], 8'h01);
    chk("R4 byte16", tx_data[16*8 +: 8], 8'h01);
    chk("R4 word7", tx_data[255:224], 32'h7403_0201);
    rd(7'h4C, d); chk("R4 readback", d, 32'h7403_0201);
  endtask

  task automatic t_launch;
    logic [31:0] d;
    wr(7'h00, 32'h0000_0001);
    start_seen = 0;
    wr(7'h08, 1); @(negedge clk);
    chk("R5 no enable", start_seen, 0);
    rd(7'h08, d); chk("R5 no launch", d, 0);
    wr(7'h00, 32'h0000_0011);
    eng_state = 4'h3;
    wr(7'h08, 1); @(negedge clk);
    chk("R6 busy blocks", start_seen, 0);
    eng_state = 0; eng_pin_busy = 1;
    rd(7'h08, d); chk("R6 pin flag", d, 32'h8000_0000);
    wr(7'h08, 1);
    chk("R6 pin blocks", start_seen, 0);
    eng_pin_busy = 0;
    @(negedge clk); bus_addr = 7'h08; bus_wdata = 1; bus_we = 1;
    @(negedge clk); bus_we = 0;
    chk("R5 pulse", eng_start, 1);
    @(negedge clk);
    chk("R5 single", eng_start, 0);
    rd(7'h08, d); chk("R6 launch bit", d, 1);
    wr(7'h08, 1);
    chk("R6 pending blocks", start_seen, 1);
    wr(7'h0C, 32'h0000_0000);
    chk("R7 hdr frozen", hdr_wr_len, 8'h1F);
    wr(7'h20, 32'hDEAD_BEEF);
    rd(7'h20, d); chk("R7 tx frozen", d, 32'h0403_0201);
    wr(7'h08, 0);
    rd(7'h08, d); chk("R11 clear", d, 0);
    wr(7'h08, 1);
    chk("R11 still pending", start_seen, 1);
    rd(7'h0C, d); chk("R11 hdr kept", d, 32'h0004_1F30);
    rd(7'h30, d); chk("R8 before done", d, 0);
    for (int i = 0; i < 8; i++) rx_data[32*i +: 32] = 32'hA0A0_0000 + i;
    done_pulse(4'b0000);
    rx_data = '0;
    rd(7'h30, d); chk("R8 rx0", d, 32'hA0A0_0000);
    rd(7'h50, d); chk("R8 rx4", d, 32'hA0A0_0004);
    rd(7'h5C, d); chk("R8 rx7", d, 32'hA0A0_0007);
    wr(7'h30, 32'h1234);
    rd(7'h30, d); chk("R8 read only", d, 32'hA0A0_0000);
    rd(7'h1C, d); chk("R9 done", d, 1);
    chk("R10 irq", irq, 1);
    rd(7'h08, d); chk("R6 idle after done", d, 0);
  endtask

  task automatic t_errors;
    logic [31:0] d;
    wr(7'h1C, 32'h1F);
    @(negedge clk);
    chk("R10 irq low", irq, 0);
    wr(7'h08, 1);
    repeat (3) @(negedge clk);
    done_pulse(4'b1000);
    rd(7'h1C, d); chk("R9 err+done", d, 32'h11);
    wr(7'h1C, 32'h01);
    rd(7'h1C, d); chk("R9 w1c", d, 32'h10);
    chk("R10 irq timeout", irq, 1);
    wr(7'h1C, 32'h00);
    rd(7'h1C, d); chk("R9 w0 keep", d, 32'h10);
    wr(7'h18, 32'h01);
    @(negedge clk);
    chk("R10 masked", irq, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_ctrl;
    t_hdr_tx;
    t_launch;
    t_errors;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule